// File: doc/BRIEF.md
# SPI Transmit Queue with Inter-Word Gap

This block feeds the serial shifter of an SPI master. Software writes 16-bit words into a 16-deep queue. One word at a time moves from the queue into a staging register. The staging register hands its word to the shifter with a one-cycle load strobe. The staging register takes the next queued word only after the shifter reports that the last bit of its current word has gone out.

Between two words the block can insert an idle gap. The gap is counted in serial clock ticks and programmed from 0 to 255; a gap of zero sends the words back to back. The block always reports how many words are waiting in the queue. A level-sensitive request asks for more data whenever that count is at or below a trigger level. A clear control empties the queue. With the queue switched off, a write goes straight into the staging register.

Top module: `spi_txq`

## Requirements
- R1: After reset, `fill_cnt` is 0, `ld_stb` is 0 and `ovf` is 0.
- R2: With `fifo_on`=1, words leave in the order they were written. Each word appears on `ld_word` in the cycle `ld_stb` is 1. `fill_cnt` reports the queued words, from 0 to 16. A word that has moved into the staging register is no longer counted.
- R3: A queue write while `fill_cnt`=16 is dropped and sets `ovf`. `ovf` stays 1 until a cycle with `ovf_clr`=1.
- R4: While a word is in the shifter, meaning from `ld_stb` until a `word_done` pulse, the staging register is not refilled, `ld_stb` stays 0 and `fill_cnt` does not fall.
- R5: After `word_done`, `ld_stb` is held off until `gap_cfg` cycles with `sclk_tick`=1 have been counted.
- R6: With `gap_cfg`=0 and a word queued, `ld_stb` is 1 in the second cycle after the `word_done` cycle.
- R7: While `ptr_clr` is 1, the queue is emptied, so `fill_cnt` reads 0 one cycle later. Writes in those cycles are dropped without setting `ovf`.
- R8: `tx_req` is 1 exactly when `fill_cnt` <= `trig_lvl`. With `trig_lvl`=0 this means the queue is empty.
- R9: With `fifo_on`=0, a write loads the staging register directly and leaves `fill_cnt` unchanged. If the shifter is idle and the gap has elapsed, `ld_stb` rises in the next cycle with that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 16 | CPU write word |
| fifo_on | input | 1 | 1: writes go through the queue; 0: writes go to the staging register |
| gap_cfg | input | 8 | Idle gap between words, in serial clock ticks |
| ptr_clr | input | 1 | Queue clear; held pointers at zero while 1 |
| trig_lvl | input | 5 | Request threshold for the fill count |
| sclk_tick | input | 1 | One pulse per serial clock cycle |
| word_done | input | 1 | Shifter pulse: last bit of the current word sent |
| ovf_clr | input | 1 | Clears the overflow flag |
| ld_word | output | 16 | Word offered to the shifter |
| ld_stb | output | 1 | Shifter load strobe |
| fill_cnt | output | 5 | Number of words in the queue |
| tx_req | output | 1 | Transmit data request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A queue write changes `fill_cnt` and `tx_req` one edge later. A direct write in bypass mode raises `ld_stb` one edge later. A `word_done` pulse leads to a refill of the staging register one edge after the shifter is freed. With a zero gap, `ld_stb` therefore follows two edges after `word_done`. With a nonzero gap, `ld_stb` follows the edge that counts the last required tick. The bench drives every input just after a falling edge and checks the outputs 1 ns after the rising edge at which each result is due. It also checks the cycles just before that edge, so an early strobe is caught.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic              stage_vld;
        logic              busy;
        logic              ovf;
    } ctl_t;
endpackage

// File: rtl/spi_txq_queue.sv
module spi_txq_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    assign full  = (q_q.cnt == CW'(DEPTH));
    assign empty = (q_q.cnt == '0);
    assign dout  = q_q.mem[q_q.rp];
    assign cnt   = q_q.cnt;

    always_comb begin
        q_d     = q_q;
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        if (clr) begin
            q_d.wp  = '0;
            q_d.rp  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) begin
                q_d.mem[q_q.wp] = din;
                q_d.wp          = (q_q.wp == AW'(DEPTH - 1)) ? '0 : q_q.wp + 1'b1;
            end
            if (do_pop)
                q_d.rp = (q_q.rp == AW'(DEPTH - 1)) ? '0 : q_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/spi_txq_gap.sv
module spi_txq_gap #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          tick,
    input  logic [GW-1:0] cfg,
    output logic          ok
);
    typedef struct packed {
        logic          run;
        logic [GW-1:0] cnt;
    } gap_t;

    gap_t g_d, g_q;

    assign ok = !g_q.run || (g_q.cnt >= cfg);

    always_comb begin
        g_d = g_q;
        if (start) begin
            g_d.run = 1'b1;
            g_d.cnt = '0;
        end else if (stop) begin
            g_d.run = 1'b0;
        end else if (g_q.run && tick && (g_q.cnt < cfg)) begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/spi_txq.sv
module spi_txq
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int GAP_W = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fifo_on,
    input  logic [GAP_W-1:0]  gap_cfg,
    input  logic              ptr_clr,
    input  logic [CW-1:0]     trig_lvl,
    input  logic              sclk_tick,
    input  logic              word_done,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] ld_word,
    output logic              ld_stb,
    output logic [CW-1:0]     fill_cnt,
    output logic              tx_req,
    output logic              ovf
);
    ctl_t c_d, c_q;

    logic              q_push, q_pop, q_full, q_empty, gap_ok;
    logic [WORD_W-1:0] q_dout;
    logic [CW-1:0]     q_cnt;

    assign q_push = wr_en && fifo_on && !ptr_clr;
    assign q_pop  = fifo_on && !c_q.stage_vld && !c_q.busy && !ptr_clr;

    spi_txq_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
        .push(q_push), .din(wr_data), .pop(q_pop),
        .dout(q_dout), .cnt(q_cnt), .full(q_full), .empty(q_empty)
    );

    spi_txq_gap #(.GW(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .start(word_done && c_q.busy),
        .stop(ld_stb), .tick(sclk_tick), .cfg(gap_cfg), .ok(gap_ok)
    );

    assign ld_stb   = c_q.stage_vld && !c_q.busy && gap_ok;
    assign ld_word  = c_q.stage;
    assign fill_cnt = q_cnt;
    assign tx_req   = (q_cnt <= trig_lvl);
    assign ovf      = c_q.ovf;

    always_comb begin
        c_d = c_q;
        if (ld_stb) begin
            c_d.stage_vld = 1'b0;
            c_d.busy      = 1'b1;
        end
        if (word_done)
            c_d.busy = 1'b0;
        if (q_pop && !q_empty) begin
            c_d.stage     = q_dout;
            c_d.stage_vld = 1'b1;
        end
        if (!fifo_on && wr_en) begin
            c_d.stage     = wr_data;
            c_d.stage_vld = 1'b1;
        end
        if (ovf_clr)
            c_d.ovf = 1'b0;
        if (q_push && q_full)
            c_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          fifo_on,
    input logic          ptr_clr,
    input logic          ovf_clr,
    input logic          ld_stb,
    input logic [CW-1:0] fill_cnt,
    input logic          ovf,
    input logic          gap_ok
);
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_clr |=> (fill_cnt == $past(fill_cnt) || fill_cnt == $past(fill_cnt) + 1'b1
                      || fill_cnt + 1'b1 == $past(fill_cnt)));

    a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_on && !ptr_clr && fill_cnt == CW'(DEPTH)) |=> ovf);

    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> !ld_stb);

    a_r5_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> gap_ok);

    a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (fill_cnt == '0));
endmodule

bind spi_txq spi_txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_on(fifo_on),
    .ptr_clr(ptr_clr), .ovf_clr(ovf_clr), .ld_stb(ld_stb),
    .fill_cnt(fill_cnt), .ovf(ovf), .gap_ok(gap_ok)
);

// File: tb/spi_txq_bench.sv
module spi_txq_bench;
    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, fifo_on = 1, ptr_clr = 0, sclk_tick = 0, word_done = 0, ovf_clr = 0;
    logic [15:0] wr_data = 0;
    logic [7:0]  gap_cfg = 0;
    logic [4:0]  trig_lvl = 0;
    logic [15:0] ld_word;
    logic        ld_stb, tx_req, ovf;
    logic [4:0]  fill_cnt;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_txq u_spi_txq (.*);

    // {words written, trig_lvl, expected fill_cnt, expected tx_req, expected ovf}
    localparam logic [16:0] VEC [7] = '{
        {5'd0,  5'd0,  5'd0,  1'b1, 1'b0},
        {5'd1,  5'd0,  5'd1,  1'b0, 1'b0},
        {5'd4,  5'd4,  5'd4,  1'b1, 1'b0},
        {5'd4,  5'd3,  5'd4,  1'b0, 1'b0},
        {5'd16, 5'd16, 5'd16, 1'b1, 1'b0},
        {5'd17, 5'd15, 5'd16, 1'b0, 1'b1},
        {5'd16, 5'd31, 5'd16, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        wr_en = 0; ptr_clr = 0; ovf_clr = 0; sclk_tick = 0; word_done = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        step();
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        word_done = 1;
        step();
        @(negedge clk);
        word_done = 0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 fill_cnt", fill_cnt, 0);
        chk("R1 ld_stb", ld_stb, 0);
        chk("R1 ovf", ovf, 0);
        chk("R8 empty req", tx_req, 1);
        @(negedge clk); rst_n = 1;

        // occupy the shifter so queued words stay queued
        wr(16'h5A5A);   // pops on the next edge, strobes after it
        step();
        chk("R2 first load strobe", ld_stb, 1);
        chk("R2 first load word", ld_word, 16'h5A5A);
        step();
        chk("R4 strobe once", ld_stb, 0);

        foreach (VEC[i]) begin
            @(negedge clk); ptr_clr = 1; ovf_clr = 1;
            step();
            drive_idle();
            trig_lvl = VEC[i][11:7];
            for (int n = 0; n < int'(VEC[i][16:12]); n++) wr(16'h1000 + 16'(n));
            step();
            chk("R2 table fill_cnt", fill_cnt, VEC[i][6:2]);
            chk("R8 table tx_req", tx_req, VEC[i][1]);
            chk("R3 table ovf", ovf, VEC[i][0]);
            chk("R4 no strobe while busy", ld_stb, 0);
        end

        // R3: sticky until cleared (queue is full here)
        wr(16'hFFFF);
        chk("R3 ovf set", ovf, 1);
        step(); step();
        chk("R3 ovf sticky", ovf, 1);
        @(negedge clk); ovf_clr = 1;
        step();
        drive_idle();
        chk("R3 ovf cleared", ovf, 0);

        // R7: clear drops writes without overflow
        @(negedge clk); ptr_clr = 1; wr_en = 1; wr_data = 16'h7777;
        step(); step();
        chk("R7 fill_cnt during clear", fill_cnt, 0);
        chk("R7 no ovf", ovf, 0);
        drive_idle();
        step();
        chk("R7 fill_cnt after clear", fill_cnt, 0);

        // R2/R4/R5: order and gap of 3 ticks
        wr(16'hA001); wr(16'hA002); wr(16'hA003);
        step(); step();
        chk("R4 held while busy", fill_cnt, 3);
        chk("R4 no strobe", ld_stb, 0);
        gap_cfg = 8'd3;
        pulse_done();     // edge frees shifter, next edge stages A001
        step();
        chk("R2 pop counted", fill_cnt, 2);
        chk("R5 gap blocks", ld_stb, 0);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); sclk_tick = 1;
            step();
            @(negedge clk); sclk_tick = 0;
            if (t < 2) chk("R5 gap still blocks", ld_stb, 0);
        end
        chk("R5 strobe after gap", ld_stb, 1);
        chk("R2 order first", ld_word, 16'hA001);
        step();

        // R6: zero gap
        gap_cfg = 8'd0;
        @(negedge clk); word_done = 1;
        step();
        @(negedge clk); word_done = 0;
        chk("R6 not yet", ld_stb, 0);
        step();
        chk("R6 back to back", ld_stb, 1);
        chk("R2 order second", ld_word, 16'hA002);
        step();

        // R9: bypass
        @(negedge clk); fifo_on = 0; word_done = 1;
        step();
        @(negedge clk); word_done = 0;
        step();
        chk("R9 queue not used", ld_stb, 0);
        wr(16'hBEEF);
        chk("R9 direct strobe", ld_stb, 1);
        chk("R9 direct word", ld_word, 16'hBEEF);
        chk("R9 fill_cnt kept", fill_cnt, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule